// File: doc/BRIEF.md
# Micro-operation driven bus datapath

This block is the execution half of a small microcoded computer. A control unit presents one 15-bit micro-operation word each clock, with bits numbered 1 to 15. Each bit enables one transfer in the datapath: a register loading, a source driving a bus, or the memory being enabled or written. The datapath holds two working registers, an ALU with eight operations, an address register, a program counter and a 256-word by 8-bit memory. All of these are joined by one shared 8-bit data bus and one shared 8-bit address bus.

Both buses are built as selection logic rather than tri-state wires. A bus that nothing drives reads as zero. The data bus is exported so the control unit can decode fetched opcodes. The address bus is exported as well, so the memory address of every cycle can be observed. Micro-operation bits 1 and 2 belong to the sequencer and have no effect here.

Top module: `ucode_datapath`

## Requirements
- R1: A synchronous active-high `rst` clears the program counter, both working registers and the address register to zero. It overrides every micro-operation in the same cycle, including a program counter load.
- R2: When no source is enabled on a bus, that bus reads as zero.
- R3: At each clock edge outside reset, the program counter takes one of these actions, in falling priority:
  - it loads the address bus when bit 6 is set;
  - otherwise it increments, modulo 256, when bit 7 is set;
  - otherwise it holds its value.
- R4: Bit 5 drives the program counter onto the data bus. In the same cycle it also drives the program counter onto the address bus.
- R5: Bit 11 loads the first working register from the data bus, and bit 12 loads the second working register from the ALU result. Each load uses the values present before the clock edge, so the second register can drive the bus and be reloaded in the same cycle.
- R6: The ALU operation code is formed as {bit 13, bit 14, bit 15}, with bit 13 as the most significant bit. With A as the first register and B as the second, the codes are:
  - 000: pass A;
  - 001: A shifted left with zero fill;
  - 010: A shifted right with zero fill;
  - 011: A+B modulo 256;
  - 100: A−B modulo 256;
  - 101: A AND B;
  - 110: A OR B;
  - 111: NOT A.
- R7: Bit 9 loads the address register from the data bus. Bit 10 drives the address register onto the address bus.
- R8: With bit 3 set and bit 4 clear, the memory word addressed by the address bus drives the data bus. This read does not change the memory.
- R9: The memory word at the address bus takes the data bus value at a clock edge only when bits 3 and 4 are both set. Bit 4 alone commits nothing and drives nothing.
- R10: At most one data bus source (bit 5, bit 8, or a memory read) is active at once. At most one address bus source (bit 5 or bit 10) is active at once. With a single source active, the bus carries exactly that source's value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mop | input | 15 | Micro-operation word, indexed [15:1] |
| data_bus | output | 8 | Shared data bus value |
| addr_bus | output | 8 | Shared address bus value |

## Verification
Two functions can act on the program counter in the same cycle: a load from the address bus and an increment. The bench sets bits 6 and 7 together, both in a directed case and in random traffic. It then reads the counter back through bit 5 and requires the loaded value, not the incremented one. The second collision is the second register driving the data bus while it loads a new ALU result. Random words combine bits 8 and 12, and the model requires the bus to carry the old register value while the register takes the new result at the edge. A reset asserted together with a load and register writes checks that clearing wins.

// File: rtl/ucode_datapath.sv
module ucode_datapath #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [15:1]  mop,
  output logic [W-1:0] data_bus,
  output logic [W-1:0] addr_bus
);
  localparam int DEPTH = 1 << W;

  logic [W-1:0] pc, r0, r1, ar, alu_y;
  logic [W-1:0] mem [DEPTH];
  logic [2:0]   alu_sel;
  logic         mem_rd, mem_wr;
  logic         unused_seq;

  assign unused_seq = ^mop[2:1];
  assign mem_rd  = mop[3] & ~mop[4];
  assign mem_wr  = mop[3] &  mop[4];
  assign alu_sel = {mop[13], mop[14], mop[15]};

  assign addr_bus = ({W{mop[5]}} & pc) | ({W{mop[10]}} & ar);
  assign data_bus = ({W{mop[5]}} & pc) | ({W{mop[8]}} & r1)
                  | ({W{mem_rd}} & mem[addr_bus]);

  always_comb begin
    case (alu_sel)
      3'd0: alu_y = r0;
      3'd1: alu_y = r0 << 1;
      3'd2: alu_y = r0 >> 1;
      3'd3: alu_y = r0 + r1;
      3'd4: alu_y = r0 - r1;
      3'd5: alu_y = r0 & r1;
      3'd6: alu_y = r0 | r1;
      3'd7: alu_y = ~r0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      r0 <= '0;
      r1 <= '0;
      ar <= '0;
    end else begin
      if (mop[6])      pc <= addr_bus;
      else if (mop[7]) pc <= pc + 1'b1;
      if (mop[11]) r0 <= data_bus;
      if (mop[12]) r1 <= alu_y;
      if (mop[9])  ar <= data_bus;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_wr) mem[addr_bus] <= data_bus;
  end

  a_r10_one_data_driver: assert property (@(posedge clk) disable iff (rst)
    $countones({mop[5], mop[8], mem_rd}) <= 1);
  a_r10_one_addr_driver: assert property (@(posedge clk) disable iff (rst)
    !(mop[5] && mop[10]));
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc == '0 && r0 == '0 && r1 == '0 && ar == '0));
  a_r3_pc_load: assert property (@(posedge clk) disable iff (rst)
    mop[6] |=> pc == $past(addr_bus));
  a_r3_pc_step: assert property (@(posedge clk) disable iff (rst)
    (!mop[6] && mop[7]) |=> pc == $past(pc) + 1'b1);
  a_r3_pc_hold: assert property (@(posedge clk) disable iff (rst)
    (!mop[6] && !mop[7]) |=> $stable(pc));
  a_r5_r0_take: assert property (@(posedge clk) disable iff (rst)
    mop[11] |=> r0 == $past(data_bus));
  a_r7_ar_take: assert property (@(posedge clk) disable iff (rst)
    mop[9] |=> ar == $past(data_bus));
  a_r9_mem_commit: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> mem[$past(addr_bus)] == $past(data_bus));
  a_r2_idle_data: assert property (@(posedge clk) disable iff (rst)
    !(mop[5] || mop[8] || mem_rd) |-> data_bus == '0);
endmodule

// File: tb/ucode_datapath_tb.sv
module ucode_datapath_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:1] mop = '0;
  logic [7:0]  data_bus, addr_bus;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] m_pc, m_r0, m_r1, m_ar;
  logic [7:0] m_mem [256];

  ucode_datapath #(.W(8)) u_dut (
    .clk(clk), .rst(rst), .mop(mop), .data_bus(data_bus), .addr_bus(addr_bus)
  );

  always #4 clk = ~clk;

  function automatic logic [15:1] b(input int n);
    logic [15:1] v;
    v = '0;
    v[n] = 1'b1;
    return v;
  endfunction

  function automatic logic [15:1] sel(input int s);
    logic [15:1] v;
    v = '0;
    v[13] = s[2];
    v[14] = s[1];
    v[15] = s[0];
    return v;
  endfunction

  function automatic logic [7:0] alu(input logic [15:1] m, input logic [7:0] a, input logic [7:0] c);
    int code;
    code = {29'd0, m[13], m[14], m[15]};
    case (code)
      0: return a;
      1: return {a[6:0], 1'b0};
      2: return {1'b0, a[7:1]};
      3: return 8'((a + c) % 256);
      4: return 8'((256 + a - c) % 256);
      5: return a & c;
      6: return a | c;
      default: return 8'hFF ^ a;
    endcase
  endfunction

  function automatic logic [7:0] exp_addr(input logic [15:1] m);
    if (m[5])  return m_pc;
    if (m[10]) return m_ar;
    return 8'h00;
  endfunction

  function automatic logic [7:0] exp_data(input logic [15:1] m);
    if (m[5]) return m_pc;
    if (m[8]) return m_r1;
    if (m[3] && !m[4]) return m_mem[exp_addr(m)];
    return 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [15:1] m, input string tag);
    logic [7:0] d, a;
    @(negedge clk);
    mop = m;
    #1;
    d = exp_data(m);
    a = exp_addr(m);
    chk({tag, " data"}, data_bus, d);
    chk({tag, " addr"}, addr_bus, a);
    @(posedge clk);
    if (m[3] && m[4]) m_mem[a] = d;
    if (m[12]) m_r1 = alu(m, m_r0, m_r1);
    if (m[11]) m_r0 = d;
    if (m[9])  m_ar = d;
    if (m[6])      m_pc = a;
    else if (m[7]) m_pc = m_pc + 8'd1;
  endtask

  task automatic do_reset(input logic [15:1] m);
    @(negedge clk);
    rst = 1'b1;
    mop = m;
    repeat (2) @(posedge clk);
    m_pc = 0; m_r0 = 0; m_r1 = 0; m_ar = 0;
    @(negedge clk);
    rst = 1'b0;
    mop = '0;
  endtask

  function automatic logic [15:1] rand_word();
    logic [15:1] m;
    int c;
    m = 15'($urandom);
    m[3] = 0; m[4] = 0; m[5] = 0; m[8] = 0; m[10] = 0;
    c = $urandom % 6;
    case (c)
      1: m[5] = 1;
      2: begin m[8] = 1; m[4] = 1'($urandom); m[10] = 1'($urandom); end
      3: begin m[3] = 1; m[10] = 1'($urandom); end
      4: begin m[8] = 1; m[3] = 1; m[4] = 1; m[10] = 1'($urandom); end
      5: begin m[5] = 1; m[3] = 1; m[4] = 1; end
      default: m[10] = 1'($urandom);
    endcase
    return m;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(731);
    m_pc = 0; m_r0 = 0; m_r1 = 0; m_ar = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 / R2: reset values and idle buses
    step('0, "R2");
    step(b(5), "R1");
    step(b(8), "R1");
    step(b(10), "R1");

    // R4 / R9: fill memory with mem[i] = i from the counter
    for (int i = 0; i < 256; i++) step(b(5) | b(3) | b(4) | b(7), "R4 R9");

    // R3: increment, load beating increment, hold
    for (int i = 0; i < 5; i++) step(b(7), "R3");
    step(b(5) | b(9), "R7");
    for (int i = 0; i < 3; i++) step(b(7), "R3");
    step(b(10) | b(6) | b(7), "R3");
    step(b(5), "R3");
    step('0, "R3");
    step(b(5), "R3");

    // R8: read
    step(b(10) | b(3), "R8");

    // R9: write without enable is ignored, then a real write
    step(b(12) | sel(7), "R6");
    step(b(8) | b(10) | b(4), "R9");
    step(b(10) | b(3), "R9");
    step(b(8) | b(10) | b(4) | b(3), "R9");
    step(b(10) | b(3), "R9");

    // R6: wrap-around add with 0xFF operands
    step(b(8) | b(9), "R7");
    step(b(10) | b(3) | b(11), "R5");
    step(b(12) | sel(3), "R6");
    step(b(8), "R6");
    step(b(12) | sel(4), "R6");
    step(b(8), "R6");

    // R5: R1 drives the bus while loading a new result
    step(b(8) | b(9) | b(12) | sel(1), "R5");
    step(b(10), "R5");
    step(b(8), "R5");

    // R1: reset wins over load and register writes
    do_reset(b(6) | b(10) | b(11) | b(12) | sel(7) | b(9));
    step(b(5), "R1");
    step(b(8), "R1");
    step(b(10), "R1");

    // R10 / R6 / R5: random traffic
    for (int i = 0; i < 3000; i++) step(rand_word(), "R10 R6 R5");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule